// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block holds two independent event counters, each 48 bits wide. Software reaches them through a small register bus. Each counter has its own 16-bit control word. The control word picks which hardware event the counter follows, using a 6-bit event code. It also carries an arm pair (enable and start), a clock-select flag, and a self-clearing clear request. A counter advances by one on every clock where its selected event is present, but only while both arm bits are set.

Four single-cycle event pulses come in from the processor on `evt_pulse`. A fifth source, elapsed time, is internal and is present on every clock. A count is read as two words: a high word that carries the top bits zero-extended, and a low word that carries the bottom 32 bits.

The register bus is a plain synchronous port with no back-pressure. A write is taken on any clock edge where `reg_we` is high. Read data is a combinational function of `reg_addr` and is valid in the same cycle. The block never stalls the bus and holds no pending request. Nothing in this block streams data, so no valid/ready pair is needed. Default offsets put the control words at 0x00 and 0x04, counter 0 at 0x10 (high word) and 0x14 (low word), and counter 1 at 0x18 (high word) and 0x1C (low word).

Top module: `evt_count_pair`

## Requirements
- R1: After reset, every control word and every counter word reads as zero.
- R2: Writing the control word of channel n (at offset CTL_OFS+4n) stores the event code from bits [5:0], the clock-select flag from bit 8, start from bit 14 and enable from bit 15. All other bits read back as zero. The clock-select flag has no effect on counting.
- R3: Writing the control word with bit 13 set zeroes that counter at the same clock edge. This takes precedence over an increment in that cycle. Bit 13 always reads back as 0.
- R4: A counter advances only while both its enable bit and its start bit are 1. With either bit at 0, the count holds.
- R5: The counter adds exactly one for each clock where its selected event is present. Code 0x23 selects elapsed time, which is present every cycle. Codes 0x06, 0x08, 0x0A and 0x10 select `evt_pulse` bits 0, 1, 2 and 3. A pulse on a bit that is not selected is not counted.
- R6: Any other event code never counts.
- R7: Counter n is read at CNT_OFS+8n, which returns the upper CNT_W-LO_W bits zero-extended, and at CNT_OFS+8n+4, which returns the lower LO_W bits.
- R8: A count of all ones wraps to zero on its next increment and keeps counting.
- R9: Writes to counter-word addresses or to unmapped addresses change no control word and no count. Unmapped addresses read as zero.
- R10: The two channels are independent. Writing one channel's control word leaves the other channel's control word and count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| evt_pulse | input | 4 | Event pulses: bit0 fetch, bit1 instruction-cache miss, bit2 instruction access, bit3 branch |

## Verification
Two actions can land on the same counter in the same cycle: a clear request written to the control word, and an increment from the selected event. The bench arms a counter on elapsed time, so an event is present in every cycle. It then writes the clear bit together with the arm bits. The low word must read zero right after that edge, and one a cycle later. This shows that the clear won and that counting resumed under the new control value. A second overlap is a control write to one channel while the other channel is counting. That case is judged by an exact count on the untouched channel.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int CODE_W  = 6;
  localparam int CTL_W   = 16;
  localparam int NUM_SRC = 4;

  // control word bit positions
  localparam int BIT_EN  = 15;
  localparam int BIT_RUN = 14;
  localparam int BIT_CLR = 13;
  localparam int BIT_CKS = 8;

  localparam logic [CODE_W-1:0] CODE_ELAPSED = 6'h23;
  // index g selects evt_pulse[g]
  localparam logic [NUM_SRC-1:0][CODE_W-1:0] SRC_CODE = {6'h10, 6'h0A, 6'h08, 6'h06};

  typedef struct packed {
    logic              en;
    logic              run;
    logic              cks;
    logic [CODE_W-1:0] code;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(ctl_t c);
    logic [CTL_W-1:0] w;
    w              = '0;
    w[BIT_EN]      = c.en;
    w[BIT_RUN]     = c.run;
    w[BIT_CKS]     = c.cks;
    w[CODE_W-1:0]  = c.code;
    return w;
  endfunction
endpackage

// File: rtl/evtcnt_sel.sv
module evtcnt_sel
  import evtcnt_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  input  logic [NUM_SRC-1:0] pulse,
  output logic               hit
);
  logic [NUM_SRC-1:0] match;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign match[g] = pulse[g] && (code == SRC_CODE[g]);
  end

  assign hit = (code == CODE_ELAPSED) || (|match);
endmodule

// File: rtl/evtcnt_chan.sv
module evtcnt_chan
  import evtcnt_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_clr,
  input  logic [CTL_W-1:0]   wr_word,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic [CTL_W-1:0]   ctl_word,
  output logic [CNT_W-1:0]   cnt
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_word[12:9], wr_word[7:6]};

  evtcnt_sel u_sel (
    .code  (ctl_q.code),
    .pulse (evt_pulse),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) begin
        ctl_q.en   <= wr_word[BIT_EN];
        ctl_q.run  <= wr_word[BIT_RUN];
        ctl_q.cks  <= wr_word[BIT_CKS];
        ctl_q.code <= wr_word[CODE_W-1:0];
      end
      if (wr_clr) begin
        cnt_q <= '0;
      end else if (ctl_q.en && ctl_q.run && hit) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ctl_word = ctl_pack(ctl_q);
  assign cnt      = cnt_q;
endmodule

// File: rtl/evt_count_pair.sv
module evt_count_pair
  import evtcnt_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int LO_W    = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_CH  = 2,
  parameter int CTL_OFS = 'h00,
  parameter int CNT_OFS = 'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse
);
  localparam int HI_W = CNT_W - LO_W;

  logic [NUM_CH-1:0]             ctl_we;
  logic [NUM_CH-1:0]             ctl_clr;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_all;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:CTL_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS + 4 * g);

    assign ctl_we[g]  = reg_we && (reg_addr == A_CTL);
    assign ctl_clr[g] = ctl_we[g] && reg_wdata[BIT_CLR];

    evtcnt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctl_we[g]),
      .wr_clr    (ctl_clr[g]),
      .wr_word   (reg_wdata[CTL_W-1:0]),
      .evt_pulse (evt_pulse),
      .ctl_word  (ctl_all[g]),
      .cnt       (cnt_all[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(CTL_OFS + 4 * c))
        reg_rdata = DATA_W'(ctl_all[c]);
      if (reg_addr == ADDR_W'(CNT_OFS + 8 * c))
        reg_rdata = DATA_W'(cnt_all[c][CNT_W-1:LO_W]);
      if (reg_addr == ADDR_W'(CNT_OFS + 8 * c + 4))
        reg_rdata = DATA_W'(cnt_all[c][LO_W-1:0]);
    end
  end

  initial begin
    if (HI_W < 1 || HI_W > DATA_W || LO_W > DATA_W)
      $error("evt_count_pair: word split does not fit the bus");
  end
endmodule

// File: rtl/evt_count_pair_chk.sv
module evt_count_pair_chk #(
  parameter int CNT_W   = 48,
  parameter int NUM_CH  = 2,
  parameter int ADDR_W  = 8,
  parameter int CNT_OFS = 'h10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [NUM_CH-1:0]             ctl_we,
  input logic [NUM_CH-1:0]             ctl_clr,
  input logic [NUM_CH-1:0][15:0]       ctl_all,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3
    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clr[g] |=> (cnt_all[g] == '0));

    // R4
    a_r4_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ctl_all[g][15] && ctl_all[g][14]) && !ctl_clr[g]) |=> $stable(cnt_all[g]));

    // R5 / R8: steps by at most one, wrapping
    a_r8_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_clr[g] |=> (cnt_all[g] == $past(cnt_all[g]) ||
                       cnt_all[g] == CNT_W'($past(cnt_all[g]) + 1'b1)));

    // R10
    a_r10_ctl_only_on_own_write: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we[g] |=> $stable(ctl_all[g]));
  end

  // R9
  a_r9_cnt_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr >= ADDR_W'(CNT_OFS)) |-> (ctl_we == '0));
endmodule

bind evt_count_pair evt_count_pair_chk #(
  .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .ctl_we(ctl_we), .ctl_clr(ctl_clr), .ctl_all(ctl_all), .cnt_all(cnt_all)
);

// File: tb/test_evt_count_pair.sv
module test_evt_count_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_m, rd_w;
  logic [3:0]  evt = '0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5ns clk = ~clk;

  evt_count_pair i_evt_count_pair (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_m), .evt_pulse(evt));

  // narrow copy so that wrap-around is reachable: 12-bit count, 8-bit low word
  evt_count_pair #(.CNT_W(12), .LO_W(8)) i_evt_count_pair_w (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_w), .evt_pulse(evt));

  typedef struct packed {
    logic       ch;
    logic [1:0] arm;   // {enable, start}
    logic [5:0] code;
    logic [3:0] pat;
    logic [7:0] n;
    logic [15:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b11, 6'h23, 4'h0, 8'd7, 16'd7, 8'd5},  // R5 elapsed
    '{1'b0, 2'b11, 6'h06, 4'h1, 8'd5, 16'd5, 8'd5},  // R5 fetch
    '{1'b1, 2'b11, 6'h08, 4'h2, 8'd6, 16'd6, 8'd5},  // R5 icache miss
    '{1'b1, 2'b11, 6'h0A, 4'h4, 8'd4, 16'd4, 8'd5},  // R5 instr access
    '{1'b0, 2'b11, 6'h10, 4'h8, 8'd9, 16'd9, 8'd5},  // R5 branch
    '{1'b0, 2'b11, 6'h06, 4'hE, 8'd5, 16'd0, 8'd5},  // R5 other bits ignored
    '{1'b1, 2'b11, 6'h01, 4'hF, 8'd5, 16'd0, 8'd6},  // R6
    '{1'b0, 2'b11, 6'h3F, 4'hF, 8'd5, 16'd0, 8'd6},  // R6
    '{1'b1, 2'b10, 6'h23, 4'h0, 8'd5, 16'd0, 8'd4},  // R4 enable only
    '{1'b0, 2'b01, 6'h06, 4'h1, 8'd5, 16'd0, 8'd4},  // R4 start only
    '{1'b1, 2'b11, 6'h06, 4'hF, 8'd3, 16'd3, 8'd5}   // R5 all pulses high
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a;
    #1ns;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(8'(a));
      check("R1", $sformatf("addr 0x%02h after reset", a), rd_m, 32'h0);
      check("R1", "narrow copy after reset", rd_w, 32'h0);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VEC[i];
      automatic logic [7:0] ca = v.ch ? 8'h04 : 8'h00;
      automatic logic [7:0] la = v.ch ? 8'h1C : 8'h14;
      wr(ca, 32'h0000_2000);
      wr(ca, (32'(v.arm) << 14) | 32'(v.code));
      for (int k = 0; k < int'(v.n); k++) begin
        evt = v.pat;
        @(negedge clk);
      end
      evt = '0;
      rd(la);
      check($sformatf("R%0d", v.req), $sformatf("vector %0d low word", i), rd_m, 32'(v.exp));
      rd(la - 8'h4);
      check("R7", $sformatf("vector %0d high word", i), rd_m, 32'h0);
      wr(ca, 32'h0);
    end

    // R2 field storage, R3 clear bit reads zero, R6 code 0x3F silent
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04);
    check("R2", "ctl1 readback", rd_m, 32'h0000_C13F);
    check("R3", "clear bit reads zero", 32'(rd_m[13]), 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h1C);
    check("R6", "code 0x3F with clock-select", rd_m, 32'h0);
    wr(8'h04, 32'h0);

    // R3 clear collides with elapsed increment
    wr(8'h00, 32'h2000);
    wr(8'h00, 32'hC023);
    repeat (5) @(negedge clk);
    rd(8'h14);
    check("R5", "elapsed before clear", rd_m, 32'd5);
    wr(8'h00, 32'hE023);
    rd(8'h14);
    check("R3", "clear wins over increment", rd_m, 32'd0);
    @(negedge clk);
    rd(8'h14);
    check("R3", "counting resumes after clear", rd_m, 32'd1);

    // R4 / R9 stop, then write counter and unmapped addresses
    wr(8'h00, 32'h0023);
    rd(8'h14);
    check("R4", "stopped value", rd_m, 32'd2);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h14); check("R9", "low word after writes", rd_m, 32'd2);
    rd(8'h10); check("R9", "high word after writes", rd_m, 32'd0);
    rd(8'h1C); check("R9", "ch1 low after writes", rd_m, 32'd0);
    rd(8'h00); check("R9", "ctl0 after writes", rd_m, 32'h0023);
    rd(8'h04); check("R9", "ctl1 after writes", rd_m, 32'h0);
    rd(8'h0C); check("R9", "unmapped read", rd_m, 32'h0);

    // R10 channel independence
    wr(8'h04, 32'h2000);
    wr(8'h04, 32'hC023);
    wr(8'h00, 32'h2000);
    rd(8'h1C); check("R10", "ch1 counts across ch0 write", rd_m, 32'd1);
    rd(8'h14); check("R10", "ch0 cleared", rd_m, 32'd0);
    rd(8'h04); check("R10", "ch1 control kept", rd_m, 32'h0000_C023);
    wr(8'h04, 32'h0);

    // R7 / R8 word split and wrap (narrow copy wraps at 4096)
    wr(8'h00, 32'h2000);
    wr(8'h00, 32'hC023);
    repeat (4095) @(negedge clk);
    rd(8'h14);
    check("R7", "main low word at 4095", rd_m, 32'd4095);
    check("R7", "narrow low word all ones", rd_w, 32'h0000_00FF);
    rd(8'h10);
    check("R7", "narrow high word all ones", rd_w, 32'h0000_000F);
    @(negedge clk);
    rd(8'h14);
    check("R8", "narrow low word wrapped", rd_w, 32'h0);
    check("R8", "main keeps counting", rd_m, 32'd4096);
    rd(8'h10);
    check("R8", "narrow high word wrapped", rd_w, 32'h0);
    @(negedge clk);
    rd(8'h14);
    check("R8", "narrow counts after wrap", rd_w, 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule